// File: doc/BRIEF.md
# Neighbour-Exchange Descending Sorter

This block holds a row of N identical cells. Each cell stores one unsigned key of W bits and two swap flags. A start pulse loads all N keys in parallel. From then on the row evolves by itself, one step per clock. In each step every cell first decides, from its own key and its close neighbours only, whether it will take the key of its left or its right neighbour. All cells then trade keys at the same clock edge. A cell never uses its own position or the row length.

The row stops when a step finds nothing to exchange. At that point the keys are in descending order, cell 0 holding the largest. A counter reports how many steps made an exchange. A step limit raises an error flag if that limit is exceeded. The sorted keys and the flags from the most recent step are always visible on the outputs.

Top module: `ca_sorter`

## Requirements
- R1: After reset, every key and every flag is zero, `busy`, `done` and `stuck` are low, and `steps` is zero.
- R2: One cycle after `start` is high, `keys_out` equals the `keys_in` value that was present with `start`. At the same point `busy` is high, `done` and `stuck` are low, and `steps` is zero. This also holds when `start` arrives while a sort is in progress, which restarts the sort.
- R3: In each step, a cell raises its take-left flag when two conditions hold. Its key must be at least the key to its right, and it must be strictly above the key to its left. Cell 0 treats its missing left neighbour as larger than any key. The last cell treats its missing right neighbour as smaller than any key.
- R4: In each step, a cell raises its take-right flag when two conditions hold. Its key must be strictly below its right neighbour's key, and that neighbour's key must be at least the key two places to the right. Keys beyond the last cell count as smaller than any key.
- R5: After a step, a cell holds its right neighbour's old key if its take-right flag is set. It holds its left neighbour's old key if its take-left flag is set. Otherwise it keeps its own key. Take-right in cell i always pairs with take-left in cell i+1, and no cell has both flags set. The keys therefore stay a permutation of the loaded set.
- R6: The first step whose flags are all zero clears `busy` and sets `done`. While `done` is high, both flag vectors read zero.
- R7: When `done` is set, `keys_out` is non-increasing from cell 0 upward. Cell i occupies bits [i*W+W-1 : i*W].
- R8: `steps` increases by one for each step that exchanges keys. Distinct keys loaded in strictly ascending order take exactly 2N-3 such steps.
- R9: If a step would exchange keys while `steps` already equals MAX_STEPS, the following happens instead. `stuck` rises, `busy` falls, `done` stays low, the keys are left unchanged, and `steps` stays at MAX_STEPS.
- R10: When not busy and without `start`, the keys, flags and status outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load `keys_in` and begin sorting |
| keys_in | input | N*W | Keys to load, cell i at bits [i*W +: W] |
| keys_out | output | N*W | Current keys, cell i at bits [i*W +: W] |
| sl_out | output | N | Take-left flags of the last step |
| sr_out | output | N | Take-right flags of the last step |
| busy | output | 1 | Sort in progress |
| done | output | 1 | Sort finished without exceeding the step limit |
| stuck | output | 1 | Step limit reached before the row settled |
| steps | output | SW | Number of exchanging steps so far |

## Verification
A fault in one cell's comparator shows at the flag outputs in the very step where that cell's neighbourhood enables the faulty case. It also corrupts `keys_out` at that same edge. The bench therefore predicts the flags and keys of every step, and a fault surfaces within one clock of the first neighbourhood that exercises it. A wrong pairing between cells can duplicate or lose a key, which the per-step permutation check exposes at once. A wrong termination rule or step count shows only at the end of a run. It is caught by comparing `done`, `stuck` and `steps` against the expected count for inputs whose step count is known.

// File: rtl/ca_sorter.sv
module ca_sorter #(
  parameter int N         = 5,
  parameter int W         = 3,
  parameter int MAX_STEPS = 2 * N,
  parameter int SW        = $clog2(MAX_STEPS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] keys_in,
  output logic [N*W-1:0] keys_out,
  output logic [N-1:0]   sl_out,
  output logic [N-1:0]   sr_out,
  output logic           busy,
  output logic           done,
  output logic           stuck,
  output logic [SW-1:0]  steps
);

  logic [W-1:0] key_q [N];
  logic [W-1:0] key_d [N];
  logic [N-1:0] sl_c, sr_c, sl_q, sr_q;
  logic         busy_q, done_q, stuck_q;
  logic [SW-1:0] steps_q;

  wire exch   = |(sl_c | sr_c);
  wire at_lim = (steps_q == SW'(MAX_STEPS));

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic gt_left, ge_right, lt_right, nxt_ge;
    if (i == 0) begin : g_lb
      assign gt_left = 1'b0;
    end else begin : g_li
      assign gt_left = key_q[i] > key_q[i-1];
    end
    if (i == N - 1) begin : g_rb
      assign ge_right = 1'b1;
      assign lt_right = 1'b0;
    end else begin : g_ri
      assign ge_right = key_q[i] >= key_q[i+1];
      assign lt_right = key_q[i] <  key_q[i+1];
    end
    if (i >= N - 2) begin : g_r2b
      assign nxt_ge = 1'b1;
    end else begin : g_r2i
      assign nxt_ge = key_q[i+1] >= key_q[i+2];
    end
    assign sl_c[i] = ge_right & gt_left;
    assign sr_c[i] = lt_right & nxt_ge;

    if (i == 0) begin : g_n0
      assign key_d[i] = sr_c[i] ? key_q[i+1] : key_q[i];
    end else if (i == N - 1) begin : g_nl
      assign key_d[i] = sl_c[i] ? key_q[i-1] : key_q[i];
    end else begin : g_nm
      assign key_d[i] = sr_c[i] ? key_q[i+1] : sl_c[i] ? key_q[i-1] : key_q[i];
    end

    assign keys_out[i*W +: W] = key_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) key_q[i] <= '0;
      sl_q    <= '0;
      sr_q    <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      stuck_q <= 1'b0;
      steps_q <= '0;
    end else if (start) begin
      for (int i = 0; i < N; i++) key_q[i] <= keys_in[i*W +: W];
      sl_q    <= '0;
      sr_q    <= '0;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      stuck_q <= 1'b0;
      steps_q <= '0;
    end else if (busy_q) begin
      sl_q <= sl_c;
      sr_q <= sr_c;
      if (!exch) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (at_lim) begin
        busy_q  <= 1'b0;
        stuck_q <= 1'b1;
      end else begin
        for (int i = 0; i < N; i++) key_q[i] <= key_d[i];
        steps_q <= steps_q + 1'b1;
      end
    end
  end

  assign sl_out = sl_q;
  assign sr_out = sr_q;
  assign busy   = busy_q;
  assign done   = done_q;
  assign stuck  = stuck_q;
  assign steps  = steps_q;

endmodule

// File: rtl/ca_sorter_chk.sv
module ca_sorter_chk #(
  parameter int N         = 5,
  parameter int W         = 3,
  parameter int MAX_STEPS = 2 * N,
  parameter int SW        = $clog2(MAX_STEPS + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N*W-1:0] keys_in,
  input logic [N*W-1:0] keys_out,
  input logic [N-1:0]   sl_out,
  input logic [N-1:0]   sr_out,
  input logic           busy,
  input logic           done,
  input logic           stuck,
  input logic [SW-1:0]  steps
);

  AST_LOAD_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (keys_out == $past(keys_in)) && busy && !done && !stuck && (steps == '0)); // R2

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_out & sr_out) == '0); // R5

  for (genvar i = 0; i < N - 1; i++) begin : g_pair
    AST_SWAP_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      sr_out[i] == sl_out[i+1]); // R5
    AST_DONE_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> keys_out[i*W +: W] >= keys_out[(i+1)*W +: W]); // R7
  end

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sl_out == '0) && (sr_out == '0) && !busy); // R6

  AST_END_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done != stuck)); // R6

  AST_STEPS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    steps <= SW'(MAX_STEPS)); // R8

  AST_STUCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck) |-> $stable(keys_out) && $stable(steps) && !done); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(keys_out) && $stable(done) && $stable(stuck) && $stable(steps)); // R10

endmodule

bind ca_sorter ca_sorter_chk #(.N(N), .W(W), .MAX_STEPS(MAX_STEPS), .SW(SW)) chk_i (.*);

// File: tb/ca_sorter_tb_top.sv
module ca_sorter_tb_top;
  localparam int N          = 5;
  localparam int W          = 3;
  localparam int MAXS       = 2 * N;
  localparam int SW         = $clog2(MAXS + 1);
  localparam int WD_MAXS    = 2;
  localparam int WD_SW      = $clog2(WD_MAXS + 1);
  localparam int CLK_PERIOD = 10;
  localparam int HI         = 1 << W;
  localparam int LO         = -1;

  typedef int karr_t [N];

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, start_wd = 1'b0;
  logic [N*W-1:0] keys_in = '0;
  logic [N*W-1:0] keys_out, wd_keys;
  logic [N-1:0]   sl_out, sr_out, wd_sl, wd_sr;
  logic           busy, done, stuck, wd_busy, wd_done, wd_stuck;
  logic [SW-1:0]  steps;
  logic [WD_SW-1:0] wd_steps;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ca_sorter #(.N(N), .W(W), .MAX_STEPS(MAXS), .SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .keys_in(keys_in), .keys_out(keys_out),
    .sl_out(sl_out), .sr_out(sr_out), .busy(busy), .done(done), .stuck(stuck), .steps(steps));

  ca_sorter #(.N(N), .W(W), .MAX_STEPS(WD_MAXS), .SW(WD_SW)) dut_wd_i (
    .clk(clk), .rst_n(rst_n), .start(start_wd), .keys_in(keys_in), .keys_out(wd_keys),
    .sl_out(wd_sl), .sr_out(wd_sr), .busy(wd_busy), .done(wd_done), .stuck(wd_stuck), .steps(wd_steps));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] pack(karr_t a);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(a[i]);
    return v;
  endfunction

  function automatic karr_t unpack(logic [N*W-1:0] v);
    karr_t a;
    for (int i = 0; i < N; i++) a[i] = int'(v[i*W +: W]);
    return a;
  endfunction

  function automatic karr_t sort_desc(karr_t a);
    karr_t s = a;
    for (int p = 0; p < N; p++)
      for (int i = 0; i < N - 1; i++)
        if (s[i] < s[i+1]) begin
          int t = s[i];
          s[i] = s[i+1];
          s[i+1] = t;
        end
    return s;
  endfunction

  task automatic step_model(input karr_t k, output logic [N-1:0] sl, output logic [N-1:0] sr,
                            output karr_t nk);
    for (int i = 0; i < N; i++) begin
      int l  = (i == 0) ? HI : k[(i == 0) ? 0 : i - 1];
      int r  = (i == N - 1) ? LO : k[(i == N - 1) ? i : i + 1];
      int r2 = (i + 2 >= N) ? LO : k[(i + 2 >= N) ? i : i + 2];
      sl[i] = (k[i] >= r) && (k[i] > l);
      sr[i] = (k[i] < r) && (r >= r2);
    end
    for (int i = 0; i < N; i++) begin
      nk[i] = k[i];
      if (sr[i] && i < N - 1) nk[i] = k[i+1];
      else if (sl[i] && i > 0) nk[i] = k[i-1];
    end
  endtask

  task automatic load_keys(karr_t a);
    @(negedge clk);
    keys_in = pack(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(keys_out == pack(a), "R2", "loaded keys", keys_out, pack(a));
    chk(busy && !done && !stuck, "R2", "busy/done/stuck", {busy, done, stuck}, 3'b100);
    chk(steps == 0, "R2", "steps after load", steps, 0);
  endtask

  task automatic run_sort(karr_t a, int exp_steps);
    int iter = 0;
    karr_t ref_s = sort_desc(a);
    logic [N*W-1:0] fin;
    load_keys(a);
    while (busy && iter < 4 * N) begin
      karr_t cur = unpack(keys_out);
      karr_t nk;
      logic [N-1:0] esl, esr;
      int prev = int'(steps);
      step_model(cur, esl, esr, nk);
      @(negedge clk);
      iter++;
      chk(sl_out == esl, "R3", "take-left flags", sl_out, esl);
      chk(sr_out == esr, "R4", "take-right flags", sr_out, esr);
      if ((esl | esr) != '0) begin
        chk(keys_out == pack(nk), "R5", "keys after step", keys_out, pack(nk));
        chk(pack(sort_desc(unpack(keys_out))) == pack(ref_s), "R5", "permutation",
            keys_out, pack(nk));
        chk(int'(steps) == prev + 1, "R8", "step count", steps, prev + 1);
      end else begin
        chk(done && !busy, "R6", "done on idle step", {done, busy}, 2'b10);
      end
    end
    chk(done && !stuck, "R6", "finished", {done, stuck}, 2'b10);
    chk(sl_out == '0 && sr_out == '0, "R6", "flags at done", {sl_out, sr_out}, 0);
    chk(keys_out == pack(ref_s), "R7", "descending result", keys_out, pack(ref_s));
    if (exp_steps >= 0) chk(int'(steps) == exp_steps, "R8", "total steps", steps, exp_steps);
    fin = keys_out;
    repeat (3) @(negedge clk);
    chk(keys_out == fin && done && !busy, "R10", "hold after done", keys_out, fin);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(keys_out == '0, "R1", "keys", keys_out, 0);
    chk(sl_out == '0 && sr_out == '0, "R1", "flags", {sl_out, sr_out}, 0);
    chk(!busy && !done && !stuck, "R1", "status", {busy, done, stuck}, 0);
    chk(steps == '0, "R1", "steps", steps, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(keys_out == '0 && !busy, "R10", "idle after reset", keys_out, 0);
  endtask

  task automatic t_ascending();
    karr_t a = '{0, 1, 2, 3, 4};
    run_sort(a, 2 * N - 3);
  endtask

  task automatic t_ascending_wide();
    karr_t a = '{1, 3, 4, 6, 7};
    run_sort(a, 2 * N - 3);
  endtask

  task automatic t_all_equal();
    karr_t a = '{5, 5, 5, 5, 5};
    run_sort(a, 0);
  endtask

  task automatic t_sorted();
    karr_t a = '{7, 6, 4, 4, 0};
    run_sort(a, 0);
  endtask

  task automatic t_mixed();
    karr_t a = '{2, 7, 7, 0, 5};
    karr_t b = '{0, 0, 7, 7, 1};
    karr_t c = '{3, 0, 6, 1, 7};
    run_sort(a, -1);
    run_sort(b, -1);
    run_sort(c, -1);
  endtask

  task automatic t_restart();
    karr_t a = '{0, 1, 2, 3, 4};
    karr_t b = '{6, 2, 0, 2, 6};
    load_keys(a);
    @(negedge clk);
    chk(busy, "R2", "still busy before restart", busy, 1);
    run_sort(b, -1);
  endtask

  task automatic t_step_limit();
    karr_t a = '{0, 1, 2, 3, 4};
    karr_t k = a;
    karr_t nk;
    logic [N-1:0] esl, esr;
    logic [N*W-1:0] frozen;
    for (int s = 0; s < WD_MAXS; s++) begin
      step_model(k, esl, esr, nk);
      k = nk;
    end
    @(negedge clk);
    keys_in = pack(a);
    start_wd = 1'b1;
    @(negedge clk);
    start_wd = 1'b0;
    chk(wd_keys == pack(a) && wd_busy, "R2", "limited unit load", wd_keys, pack(a));
    repeat (WD_MAXS) @(negedge clk);
    chk(wd_keys == pack(k), "R5", "keys before limit", wd_keys, pack(k));
    chk(wd_busy && !wd_stuck, "R9", "running at limit", {wd_busy, wd_stuck}, 2'b10);
    frozen = wd_keys;
    @(negedge clk);
    chk(wd_stuck && !wd_busy && !wd_done, "R9", "stuck raised", {wd_stuck, wd_busy, wd_done}, 3'b100);
    chk(wd_keys == frozen, "R9", "keys frozen", wd_keys, frozen);
    chk(int'(wd_steps) == WD_MAXS, "R9", "steps at limit", wd_steps, WD_MAXS);
    repeat (3) @(negedge clk);
    chk(wd_keys == frozen && wd_stuck, "R10", "hold after stuck", wd_keys, frozen);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL R6 watchdog: actual no finish expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_ascending();
    t_ascending_wide();
    t_all_equal();
    t_sorted();
    t_mixed();
    t_restart();
    t_step_limit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule